// File: doc/BRIEF.md
# Single-Accumulator Processor with Device Transfer Instructions

This block is a minimal processor built around one 16-bit accumulator. Every instruction is one 16-bit word. The top four bits select the operation and the low twelve bits give an operand. For the memory operations, that operand is a word address. For the two device operations, it is instead the number of a peripheral port, so the accumulator can be filled from a device or sent to one without placing the device in the memory map.

Each instruction runs in two phases. First the word at the program counter is read into the instruction register, and the counter steps by one. Then the decoded operation runs. Memory is a synchronous port: a read strobe in one cycle returns data in the next. The device side carries a port number, separate read and write strobes, and a ready input from the device. A device operation waits in its execute phase until ready is seen. The program counter starts from a parameter whose default is 0x300. Execution stops on a halt instruction.

Top module: `acc_cpu`

## Requirements
- R1: While reset is held, and on release, no write strobe and no device strobe is active and `halted` is low. The first memory read after reset is at address `RESET_PC` (0x300 by default).
- R2: An instruction word carries its opcode in bits [15:12] and its operand in bits [11:0]. Instructions are fetched from consecutive addresses, starting at `RESET_PC`, with the counter stepping by one per instruction.
- R3: Opcode 0x3 raises `io_rd` with `io_dev` equal to the operand. The strobe is held, with `io_dev` stable, until `io_ready` is high. In that cycle the accumulator takes `io_rdata`.
- R4: Opcode 0x7 raises `io_wr` with `io_dev` equal to the operand and `io_wdata` equal to the accumulator. All of these are held stable until `io_ready` is high, and `io_wr` is low in the following cycle.
- R5: Opcode 0x5 adds the memory word at the operand address to the accumulator, modulo 2^16, with no carry kept.
- R6: Opcode 0x1 loads the accumulator from the memory word at the operand address. Opcode 0x2 writes the accumulator to that address.
- R7: Opcode 0x0 sets `halted`, which stays high. After that no memory or device strobe is ever raised again.
- R8: Opcodes 0x4, 0x6 and 0x8 to 0xF leave the accumulator and memory unchanged and make no device access.
- R9: At most one of `mem_rd`, `mem_wr`, `io_rd` and `io_wr` is high in any cycle.
- R10: The program 0x3005, 0x5940, 0x7006, 0x0000 placed at 0x300, with 0x0002 at 0x940 and device 5 returning 3, writes 5 to device 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 12 | Memory word address |
| mem_rd | output | 1 | Memory read strobe; data is expected on `mem_rdata` in the next cycle |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 16 | Memory write data (the accumulator) |
| mem_rdata | input | 16 | Memory read data |
| io_dev | output | 12 | Device port number for a device transfer |
| io_rd | output | 1 | Device read strobe |
| io_wr | output | 1 | Device write strobe |
| io_wdata | output | 16 | Data sent to the device (the accumulator) |
| io_rdata | input | 16 | Data returned by the device, valid with `io_ready` |
| io_ready | input | 1 | Device completes the pending transfer |
| halted | output | 1 | High once a halt instruction has executed |

## Verification
The three-word device program is run with fixed values, and its single output word shows that fetch order, operand decoding and the add all work together. Short directed programs are also run. One places every unused opcode between a load and an output, which separates a true no-op from a stray accumulator update. Another adds 0xFFFF to 3, which exposes any carry leaking into the result. Random programs then mix loads, stores, adds, device transfers and no-ops over random addresses, data and device numbers, with device ready delays of zero to six cycles. Comparing every device output and the final data memory against a bench interpreter shows whether hold-until-ready, store addressing and accumulator sourcing are all correct.

// File: rtl/acc_cpu_pkg.sv
`timescale 1ns/1ps
package acc_cpu_pkg;

  // opcode values (top nibble of the instruction word)
  localparam logic [3:0] OPC_HALT = 4'h0;
  localparam logic [3:0] OPC_LDM  = 4'h1;
  localparam logic [3:0] OPC_STM  = 4'h2;
  localparam logic [3:0] OPC_IN   = 4'h3;
  localparam logic [3:0] OPC_ADD  = 4'h5;
  localparam logic [3:0] OPC_OUT  = 4'h7;

  typedef enum logic [2:0] {
    ST_FETCH,
    ST_LOAD_IR,
    ST_EXEC,
    ST_MEMRD,
    ST_HALT
  } state_e;

  typedef enum logic [1:0] {
    AC_HOLD,
    AC_MEM,
    AC_ADD,
    AC_IO
  } ac_src_e;

endpackage

// File: rtl/acc_cpu_rst_sync.sv
`timescale 1ns/1ps
module acc_cpu_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/acc_cpu_ctrl.sv
`timescale 1ns/1ps
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
#(
  parameter int OPW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [OPW-1:0] opcode,
  input  logic           io_ready,
  output logic           ir_en,
  output logic           pc_en,
  output ac_src_e        ac_src,
  output logic           addr_from_ir,
  output logic           mem_rd,
  output logic           mem_wr,
  output logic           io_rd,
  output logic           io_wr,
  output logic           halted
);

  state_e state_q, state_d;

  // next state and control decode
  always_comb begin
    state_d      = state_q;
    ir_en        = 1'b0;
    pc_en        = 1'b0;
    ac_src       = AC_HOLD;
    addr_from_ir = 1'b0;
    mem_rd       = 1'b0;
    mem_wr       = 1'b0;
    io_rd        = 1'b0;
    io_wr        = 1'b0;
    unique case (state_q)
      ST_FETCH: begin
        mem_rd  = 1'b1;
        state_d = ST_LOAD_IR;
      end
      ST_LOAD_IR: begin
        ir_en   = 1'b1;
        pc_en   = 1'b1;
        state_d = ST_EXEC;
      end
      ST_EXEC: begin
        case (opcode)
          OPC_LDM, OPC_ADD: begin
            mem_rd       = 1'b1;
            addr_from_ir = 1'b1;
            state_d      = ST_MEMRD;
          end
          OPC_STM: begin
            mem_wr       = 1'b1;
            addr_from_ir = 1'b1;
            state_d      = ST_FETCH;
          end
          OPC_IN: begin
            io_rd = 1'b1;
            if (io_ready) begin
              ac_src  = AC_IO;
              state_d = ST_FETCH;
            end
          end
          OPC_OUT: begin
            io_wr = 1'b1;
            if (io_ready) begin
              state_d = ST_FETCH;
            end
          end
          OPC_HALT: begin
            state_d = ST_HALT;
          end
          default: begin
            state_d = ST_FETCH;
          end
        endcase
      end
      ST_MEMRD: begin
        ac_src  = (opcode == OPC_ADD) ? AC_ADD : AC_MEM;
        state_d = ST_FETCH;
      end
      ST_HALT: begin
        state_d = ST_HALT;
      end
      default: begin
        state_d = ST_FETCH;
      end
    endcase
  end

  // state register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_FETCH;
    end else begin
      state_q <= state_d;
    end
  end

  assign halted = (state_q == ST_HALT);

endmodule

// File: rtl/acc_cpu_dp.sv
`timescale 1ns/1ps
module acc_cpu_dp
  import acc_cpu_pkg::*;
#(
  parameter int             DW       = 16,
  parameter int             AW       = 12,
  parameter int             OPW      = 4,
  parameter logic [AW-1:0]  RESET_PC = 'h300
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ir_en,
  input  logic           pc_en,
  input  ac_src_e        ac_src,
  input  logic           addr_from_ir,
  input  logic [DW-1:0]  mem_rdata,
  input  logic [DW-1:0]  io_rdata,
  output logic [OPW-1:0] opcode,
  output logic [AW-1:0]  field,
  output logic [DW-1:0]  ac,
  output logic [AW-1:0]  mem_addr
);

  localparam int IW = OPW + AW;

  logic [AW-1:0] pc_q, pc_d;
  logic [IW-1:0] ir_q, ir_d;
  logic [DW-1:0] ac_q, ac_d;
  logic          ac_en;

  // next values
  always_comb begin
    pc_d  = pc_q + AW'(1);
    ir_d  = mem_rdata[IW-1:0];
    ac_en = (ac_src != AC_HOLD);
    unique case (ac_src)
      AC_MEM:  ac_d = mem_rdata;
      AC_ADD:  ac_d = ac_q + mem_rdata;
      AC_IO:   ac_d = io_rdata;
      default: ac_d = ac_q;
    endcase
  end

  // registers with explicit enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q <= RESET_PC;
      ir_q <= '0;
      ac_q <= '0;
    end else begin
      if (pc_en) pc_q <= pc_d;
      if (ir_en) ir_q <= ir_d;
      if (ac_en) ac_q <= ac_d;
    end
  end

  assign opcode   = ir_q[IW-1 -: OPW];
  assign field    = ir_q[AW-1:0];
  assign ac       = ac_q;
  assign mem_addr = addr_from_ir ? field : pc_q;

endmodule

// File: rtl/acc_cpu.sv
`timescale 1ns/1ps
module acc_cpu
  import acc_cpu_pkg::*;
#(
  parameter int            DW       = 16,
  parameter int            AW       = 12,
  parameter logic [AW-1:0] RESET_PC = 'h300
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [AW-1:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic [AW-1:0] io_dev,
  output logic          io_rd,
  output logic          io_wr,
  output logic [DW-1:0] io_wdata,
  input  logic [DW-1:0] io_rdata,
  input  logic          io_ready,
  output logic          halted
);

  localparam int OPW = DW - AW;

  logic           rst_sync_n;
  logic [OPW-1:0] opcode;
  logic [AW-1:0]  field;
  logic [DW-1:0]  ac;
  logic           ir_en;
  logic           pc_en;
  logic           addr_from_ir;
  ac_src_e        ac_src;

  acc_cpu_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  acc_cpu_ctrl #(.OPW(OPW)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .opcode       (opcode),
    .io_ready     (io_ready),
    .ir_en        (ir_en),
    .pc_en        (pc_en),
    .ac_src       (ac_src),
    .addr_from_ir (addr_from_ir),
    .mem_rd       (mem_rd),
    .mem_wr       (mem_wr),
    .io_rd        (io_rd),
    .io_wr        (io_wr),
    .halted       (halted)
  );

  acc_cpu_dp #(
    .DW       (DW),
    .AW       (AW),
    .OPW      (OPW),
    .RESET_PC (RESET_PC)
  ) u_dp (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .ir_en        (ir_en),
    .pc_en        (pc_en),
    .ac_src       (ac_src),
    .addr_from_ir (addr_from_ir),
    .mem_rdata    (mem_rdata),
    .io_rdata     (io_rdata),
    .opcode       (opcode),
    .field        (field),
    .ac           (ac),
    .mem_addr     (mem_addr)
  );

  assign mem_wdata = ac;
  assign io_wdata  = ac;
  assign io_dev    = field;

endmodule

// File: rtl/acc_cpu_chk.sv
`timescale 1ns/1ps
module acc_cpu_chk #(
  parameter int DW = 16,
  parameter int AW = 12
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mem_rd,
  input logic          mem_wr,
  input logic          io_rd,
  input logic          io_wr,
  input logic          io_ready,
  input logic          halted,
  input logic [AW-1:0] io_dev,
  input logic [DW-1:0] io_wdata
);

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({mem_rd, mem_wr, io_rd, io_wr}) <= 1);

  assert_in_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && !io_ready) |=> (io_rd && $stable(io_dev)));

  assert_out_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && !io_ready) |=> (io_wr && $stable(io_dev) && $stable(io_wdata)));

  assert_out_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_ready) |=> !io_wr);

  assert_halt_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && !mem_rd && !mem_wr && !io_rd && !io_wr));

endmodule

bind acc_cpu acc_cpu_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mem_rd   (mem_rd),
  .mem_wr   (mem_wr),
  .io_rd    (io_rd),
  .io_wr    (io_wr),
  .io_ready (io_ready),
  .halted   (halted),
  .io_dev   (io_dev),
  .io_wdata (io_wdata)
);

// File: tb/tb_acc_cpu.sv
`timescale 1ns/1ps
module tb_acc_cpu;

  localparam int DW = 16;
  localparam int AW = 12;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] mem_addr;
  logic          mem_rd, mem_wr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;
  logic [AW-1:0] io_dev;
  logic          io_rd, io_wr;
  logic [DW-1:0] io_wdata;
  logic [DW-1:0] io_rdata;
  logic          io_ready;
  logic          halted;

  always #5 clk = ~clk;

  acc_cpu dut (
    .clk(clk), .rst_n(rst_n),
    .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .io_dev(io_dev), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .io_ready(io_ready),
    .halted(halted)
  );

  logic [15:0] mem     [0:4095];
  logic [15:0] ref_mem [0:4095];
  logic [11:0] got_dev[$];
  logic [15:0] got_dat[$];
  logic [11:0] exp_dev[$];
  logic [15:0] exp_dat[$];

  int  n_chk = 0;
  int  n_bad = 0;
  int  rd_idx;
  bit  use_fixed;
  logic [15:0] fixed_val;
  int  seed_off;
  int  wait_max;
  int  wcnt;
  int  ready_delay;
  int  halt_viol;
  bit  seen_first;
  logic [11:0] first_addr;
  bit  running;

  function automatic logic [15:0] devval(input logic [11:0] d, input int k);
    int v;
    if (use_fixed) return fixed_val;
    v = int'(d) * 37 + k * 101 + seed_off;
    return v[15:0];
  endfunction

  task automatic check(input string tag, input bit ok, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  // memory and device models, all acting away from the rising edge
  always @(negedge clk) begin
    if (running && rst_n) begin
      if (mem_rd) mem_rdata = mem[mem_addr];
      if (mem_wr) mem[mem_addr] = mem_wdata;
      if (!seen_first && mem_rd) begin
        seen_first = 1'b1;
        first_addr = mem_addr;
      end
      if (halted && (mem_rd || mem_wr || io_rd || io_wr)) halt_viol++;
      if (io_ready) begin
        io_ready = 1'b0;
      end else if (io_rd || io_wr) begin
        if (wcnt >= ready_delay) begin
          io_ready = 1'b1;
          if (io_rd) begin
            io_rdata = devval(io_dev, rd_idx);
            rd_idx++;
          end else begin
            got_dev.push_back(io_dev);
            got_dat.push_back(io_wdata);
          end
          wcnt = 0;
          ready_delay = $urandom_range(wait_max, 0);
        end else begin
          wcnt++;
        end
      end
    end
  end

  // bench interpreter of the instruction set
  task automatic run_ref();
    logic [11:0] pc;
    logic [15:0] ac, ins;
    int k;
    pc = 12'h300; ac = 16'h0; k = 0;
    for (int i = 0; i < 4096; i++) ref_mem[i] = mem[i];
    exp_dev.delete(); exp_dat.delete();
    for (int s = 0; s < 2000; s++) begin
      ins = ref_mem[pc];
      pc = pc + 12'd1;
      case (ins[15:12])
        4'h1: ac = ref_mem[ins[11:0]];
        4'h2: ref_mem[ins[11:0]] = ac;
        4'h3: begin ac = devval(ins[11:0], k); k++; end
        4'h5: ac = ac + ref_mem[ins[11:0]];
        4'h7: begin exp_dev.push_back(ins[11:0]); exp_dat.push_back(ac); end
        4'h0: break;
        default: ;
      endcase
    end
  endtask

  task automatic run_prog(input string tag);
    int cyc;
    rst_n = 1'b0;
    running = 1'b0;
    io_ready = 1'b0;
    io_rdata = '0;
    mem_rdata = '0;
    rd_idx = 0; wcnt = 0; halt_viol = 0;
    ready_delay = $urandom_range(wait_max, 0);
    seen_first = 1'b0;
    got_dev.delete(); got_dat.delete();
    run_ref();
    repeat (3) @(negedge clk);
    check({tag, " R1 reset quiet"}, !halted && !mem_wr && !io_rd && !io_wr,
          int'({halted, mem_wr, io_rd, io_wr}), 0);
    running = 1'b1;
    rst_n = 1'b1;
    cyc = 0;
    while (!halted && cyc < 20000) begin
      @(negedge clk);
      cyc++;
    end
    repeat (20) @(negedge clk);
    check({tag, " R1 first fetch"}, seen_first && first_addr == 12'h300,
          int'(first_addr), 'h300);
    check({tag, " R7 halted"}, halted == 1'b1, int'(halted), 1);
    check({tag, " R7 quiet after halt"}, halt_viol == 0, halt_viol, 0);
    check({tag, " R4 output count"}, got_dat.size() == exp_dat.size(),
          got_dat.size(), exp_dat.size());
    for (int i = 0; i < exp_dat.size() && i < got_dat.size(); i++) begin
      check({tag, " R3 R4 R5 output word"},
            got_dev[i] == exp_dev[i] && got_dat[i] == exp_dat[i],
            int'({got_dev[i], got_dat[i]}), int'({exp_dev[i], exp_dat[i]}));
    end
    begin
      int bad_at;
      bad_at = -1;
      for (int a = 'h900; a < 'hA00; a++) begin
        if (bad_at < 0 && mem[a] !== ref_mem[a]) bad_at = a;
      end
      check({tag, " R6 data memory"}, bad_at < 0,
            bad_at < 0 ? 0 : int'(mem[bad_at]), bad_at < 0 ? 0 : int'(ref_mem[bad_at]));
    end
  endtask

  task automatic clear_mem();
    for (int i = 0; i < 4096; i++) mem[i] = 16'h0;
  endtask

  function automatic logic [15:0] rand_ins();
    int pick;
    logic [3:0] op;
    logic [11:0] f;
    pick = $urandom_range(9, 0);
    case (pick)
      0, 1: op = 4'h1;
      2:    op = 4'h2;
      3:    op = 4'h3;
      4, 5: op = 4'h5;
      6, 7: op = 4'h7;
      default: begin
        op = 4'(($urandom_range(11, 0) < 2) ? 4 + 2 * $urandom_range(1, 0)
                                             : $urandom_range(15, 8));
      end
    endcase
    if (op == 4'h3 || op == 4'h7) f = 12'($urandom_range(15, 0));
    else f = 12'h900 + 12'($urandom_range(255, 0));
    return {op, f};
  endfunction

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 1'b0;
    running = 1'b0;
    io_ready = 1'b0;
    seed_off = 0;

    // R10 R2: three-word device program
    clear_mem();
    mem['h300] = 16'h3005; mem['h301] = 16'h5940;
    mem['h302] = 16'h7006; mem['h303] = 16'h0000;
    mem['h940] = 16'h0002;
    use_fixed = 1'b1; fixed_val = 16'd3; wait_max = 0;
    run_prog("ref-prog");
    check("R10 R2 device 6 gets 5",
          got_dat.size() == 1 && got_dev[0] == 12'd6 && got_dat[0] == 16'd5,
          got_dat.size() > 0 ? int'({got_dev[0], got_dat[0]}) : -1, 'h6_0005);

    // R8: unused opcodes leave the accumulator untouched
    clear_mem();
    mem['h300] = 16'h1900;
    for (int i = 0; i < 10; i++) begin
      logic [3:0] nop;
      nop = (i == 0) ? 4'h4 : (i == 1) ? 4'h6 : 4'(i + 6);
      mem['h301 + i] = {nop, 12'h901};
    end
    mem['h30B] = 16'h7001; mem['h30C] = 16'h0000;
    mem['h900] = 16'h1234; mem['h901] = 16'hBEEF;
    use_fixed = 1'b0; wait_max = 2;
    run_prog("nop");
    check("R8 no-op keeps accumulator",
          got_dat.size() == 1 && got_dat[0] == 16'h1234 && mem['h901] == 16'hBEEF,
          got_dat.size() > 0 ? int'(got_dat[0]) : -1, 'h1234);

    // R5: add wraps with no carry
    clear_mem();
    mem['h300] = 16'h1900; mem['h301] = 16'h5901;
    mem['h302] = 16'h7002; mem['h303] = 16'h2902; mem['h304] = 16'h0000;
    mem['h900] = 16'hFFFF; mem['h901] = 16'h0003;
    wait_max = 0;
    run_prog("wrap");
    check("R5 add wraps", got_dat.size() == 1 && got_dat[0] == 16'h0002,
          got_dat.size() > 0 ? int'(got_dat[0]) : -1, 2);
    check("R6 store of sum", mem['h902] == 16'h0002, int'(mem['h902]), 2);

    // random programs with random ready delays
    for (int t = 0; t < 24; t++) begin
      int len;
      clear_mem();
      for (int a = 'h900; a < 'hA00; a++) mem[a] = 16'($urandom());
      len = $urandom_range(60, 10);
      for (int i = 0; i < len; i++) mem['h300 + i] = rand_ins();
      mem['h300 + len] = 16'h0000;
      seed_off = int'($urandom_range(65535, 0));
      wait_max = t % 7;
      run_prog($sformatf("rand%0d", t));
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R7 actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule